// File: doc/BRIEF.md
# PCI Configuration Base Address Register

This block is a single 32-bit base address register for a PCI target's configuration space, together with the address comparator it feeds. Configuration writes land on the register through four byte-lane enables. Configuration reads return the register value. Bits below the decode window are fixed, so firmware can size the window. It writes all ones, reads the value back, finds the lowest bit that reads one, and then writes an aligned base address.

The comparator watches bus addresses and raises a hit when three things hold: the cycle's address space matches the register's type, the matching space-enable input is on, and the address bits above the window equal the stored base. Parameters choose memory or I/O space, the window size as a power of two, and the prefetchable flag of a memory window. The default is a 4 KB memory window.

Top module: `pci_bar`

## Requirements
- R1: Bit 0 of the read value is fixed: 1 when BAR_IS_IO is set, 0 for a memory register; writes never change it.
- R2: For a memory register, bits 2:1 read 00 and bit 3 reads the PREFETCH parameter. For an I/O register, bit 1 reads 0.
- R3: Bits from 0 up to DECODE_LOG2-1 that are not type bits read zero whatever is written. After an all-ones write, the read value is the all-ones mask above the window ORed with the type bits (0xFFFFF000 plus type bits for the default 4 KB memory window).
- R4: After reset, every writable bit (DECODE_LOG2 through 31) reads zero, so the read value equals the type bits alone.
- R5: During a write, cfg_be_i[k] enables bits 8k+7 to 8k; a lane whose enable is 0 keeps its previous contents.
- R6: The register changes only on a clock edge where cfg_sel_i and cfg_wr_i are both 1. cfg_rdata_o reads zero while cfg_sel_i is 0. A write is visible on cfg_rdata_o from the cycle after its edge.
- R7: hit_o is combinational. It is 1 when three conditions hold: bus_is_io_i equals BAR_IS_IO; the enable for that space (io_en_i for I/O, mem_en_i for memory) is 1; and bus_addr_i bits 31 to DECODE_LOG2 equal the stored base.
- R8: hit_o is 0 when the space enable is 0 or when the cycle's space differs from the register's type, even if the address matches.
- R9: An I/O register allows DECODE_LOG2 only from 2 to 8 (at most 256 bytes), and its bit 2 is never fixed at one. An I/O register with a 256-byte window reads 0xFFFFFF01 after an all-ones write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_sel_i | input | 1 | Configuration access addresses this register |
| cfg_wr_i | input | 1 | Configuration access is a write |
| cfg_be_i | input | 4 | Byte-lane write enables |
| cfg_wdata_i | input | 32 | Configuration write data |
| cfg_rdata_o | output | 32 | Configuration read data |
| mem_en_i | input | 1 | Memory space decode enable |
| io_en_i | input | 1 | I/O space decode enable |
| bus_is_io_i | input | 1 | Current bus cycle targets I/O space |
| bus_addr_i | input | 32 | Current bus cycle address |
| hit_o | output | 1 | Address falls inside this register's window |

## Verification
The bench drives a memory instance and an I/O instance of the block with the same stimulus. The sizing probe must return exactly the window mask plus type bits. A design that let low bits be written would report a smaller window than it decodes. Partial byte-enable writes are checked lane by lane, since a design that ignored the enables would corrupt base bytes the host never meant to touch. Hit is checked with the enable off and with the wrong space selected. A design that skipped either gate would claim cycles meant for another target.

// File: rtl/pci_bar_pkg.sv
package pci_bar_pkg;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned LANES  = ADDR_W / 8;

  // fixed low bits: type flag, memory locator/prefetch
  function automatic logic [ADDR_W-1:0] type_bits(input bit is_io, input bit pref);
    logic [ADDR_W-1:0] v;
    v = '0;
    if (is_io) v[0] = 1'b1;
    else       v[3] = pref;
    return v;
  endfunction
endpackage

// File: rtl/pci_bar_store.sv
module pci_bar_store
  import pci_bar_pkg::*;
#(
  parameter int unsigned DECODE_LOG2 = 12
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          we_i,
  input  logic [LANES-1:0]              be_i,
  input  logic [ADDR_W-1:0]             wdata_i,
  output logic [ADDR_W-1:DECODE_LOG2]   base_o
);
  logic unused_low;
  assign unused_low = ^{wdata_i[DECODE_LOG2-1:0], be_i};

  for (genvar b = DECODE_LOG2; b < ADDR_W; b++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 base_o[b] <= 1'b0;
      else if (we_i && be_i[b/8])  base_o[b] <= wdata_i[b];
    end
  end
endmodule

// File: rtl/pci_bar_match.sv
module pci_bar_match
  import pci_bar_pkg::*;
#(
  parameter int unsigned DECODE_LOG2 = 12,
  parameter bit          BAR_IS_IO   = 1'b0
) (
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic                        is_io_i,
  input  logic                        mem_en_i,
  input  logic                        io_en_i,
  input  logic [ADDR_W-1:DECODE_LOG2] base_i,
  output logic                        hit_o
);
  logic [ADDR_W-1:0] base_full;
  logic              space_ok;
  logic              addr_ok;

  assign base_full = {base_i, {DECODE_LOG2{1'b0}}};
  assign addr_ok   = (((addr_i ^ base_full) >> DECODE_LOG2) == '0);

  if (BAR_IS_IO) begin : g_io
    assign space_ok = is_io_i && io_en_i;
  end else begin : g_mem
    assign space_ok = !is_io_i && mem_en_i;
  end

  assign hit_o = space_ok && addr_ok;
endmodule

// File: rtl/pci_bar_rdmux.sv
module pci_bar_rdmux
  import pci_bar_pkg::*;
#(
  parameter int unsigned DECODE_LOG2 = 12,
  parameter bit          BAR_IS_IO   = 1'b0,
  parameter bit          PREFETCH    = 1'b0
) (
  input  logic                        sel_i,
  input  logic [ADDR_W-1:DECODE_LOG2] base_i,
  output logic [ADDR_W-1:0]           rdata_o
);
  localparam logic [ADDR_W-1:0] FIXED = type_bits(BAR_IS_IO, PREFETCH);

  always_comb begin
    rdata_o = '0;
    if (sel_i) rdata_o = {base_i, FIXED[DECODE_LOG2-1:0]};
  end
endmodule

// File: rtl/pci_bar.sv
module pci_bar
  import pci_bar_pkg::*;
#(
  parameter bit          BAR_IS_IO   = 1'b0,
  parameter int unsigned DECODE_LOG2 = 12,
  parameter bit          PREFETCH    = 1'b0
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cfg_sel_i,
  input  logic        cfg_wr_i,
  input  logic [3:0]  cfg_be_i,
  input  logic [31:0] cfg_wdata_i,
  output logic [31:0] cfg_rdata_o,
  input  logic        mem_en_i,
  input  logic        io_en_i,
  input  logic        bus_is_io_i,
  input  logic [31:0] bus_addr_i,
  output logic        hit_o
);
  localparam int unsigned MIN_LOG2 = BAR_IS_IO ? 2 : 4;
  localparam int unsigned MAX_LOG2 = BAR_IS_IO ? 8 : 31;

  if (DECODE_LOG2 < MIN_LOG2 || DECODE_LOG2 > MAX_LOG2) begin : g_bad_size
    $error("pci_bar: DECODE_LOG2 out of range for selected space");
  end

  logic [ADDR_W-1:DECODE_LOG2] base_q;
  logic                        wr_en;

  assign wr_en = cfg_sel_i && cfg_wr_i;

  pci_bar_store #(.DECODE_LOG2(DECODE_LOG2)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_en),
    .be_i    (cfg_be_i),
    .wdata_i (cfg_wdata_i),
    .base_o  (base_q)
  );

  pci_bar_rdmux #(
    .DECODE_LOG2(DECODE_LOG2), .BAR_IS_IO(BAR_IS_IO), .PREFETCH(PREFETCH)
  ) u_rdmux (
    .sel_i   (cfg_sel_i),
    .base_i  (base_q),
    .rdata_o (cfg_rdata_o)
  );

  pci_bar_match #(.DECODE_LOG2(DECODE_LOG2), .BAR_IS_IO(BAR_IS_IO)) u_match (
    .addr_i   (bus_addr_i),
    .is_io_i  (bus_is_io_i),
    .mem_en_i (mem_en_i),
    .io_en_i  (io_en_i),
    .base_i   (base_q),
    .hit_o    (hit_o)
  );
endmodule

// File: rtl/pci_bar_chk.sv
module pci_bar_chk #(
  parameter bit          BAR_IS_IO   = 1'b0,
  parameter int unsigned DECODE_LOG2 = 12,
  parameter bit          PREFETCH    = 1'b0
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  cfg_sel_i,
  input logic                  cfg_wr_i,
  input logic [31:0]           cfg_rdata_o,
  input logic                  mem_en_i,
  input logic                  io_en_i,
  input logic                  bus_is_io_i,
  input logic [31:0]           bus_addr_i,
  input logic                  hit_o,
  input logic [31:DECODE_LOG2] base_i
);
  localparam logic [31:0] LOW_EXP = BAR_IS_IO ? 32'h1 : (PREFETCH ? 32'h8 : 32'h0);

  initial a_r9_io_window: assert (!BAR_IS_IO || (DECODE_LOG2 >= 2 && DECODE_LOG2 <= 8));

  a_r3_low_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_sel_i |-> cfg_rdata_o[DECODE_LOG2-1:0] == LOW_EXP[DECODE_LOG2-1:0]);

  a_r6_unsel_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_sel_i |-> cfg_rdata_o == 32'h0);

  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cfg_sel_i && cfg_wr_i) |=> $stable(base_i));

  a_r7_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> bus_addr_i[31:DECODE_LOG2] == base_i);

  a_r8_enable_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_en_i && !io_en_i) |-> !hit_o);

  a_r8_space: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_is_io_i != BAR_IS_IO) |-> !hit_o);
endmodule

bind pci_bar pci_bar_chk #(
  .BAR_IS_IO(BAR_IS_IO), .DECODE_LOG2(DECODE_LOG2), .PREFETCH(PREFETCH)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cfg_sel_i(cfg_sel_i), .cfg_wr_i(cfg_wr_i),
  .cfg_rdata_o(cfg_rdata_o), .mem_en_i(mem_en_i), .io_en_i(io_en_i),
  .bus_is_io_i(bus_is_io_i), .bus_addr_i(bus_addr_i), .hit_o(hit_o),
  .base_i(base_q)
);

// File: tb/pci_bar_bench.sv
module pci_bar_bench;
  localparam int CLK_PERIOD = 10;
  localparam int M_LOG2 = 12;
  localparam int I_LOG2 = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, wr = 1'b0, mem_en = 1'b0, io_en = 1'b0, is_io = 1'b0;
  logic [3:0]  be = 4'h0;
  logic [31:0] wdata = '0, addr = '0;
  logic [31:0] rd_m, rd_i;
  logic        hit_m, hit_i;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 1'b0;

  // reference state: full 32-bit image of written bits
  logic [31:0] ref_m = '0, ref_i = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pci_bar #(.BAR_IS_IO(1'b0), .DECODE_LOG2(M_LOG2), .PREFETCH(1'b1)) u_pci_bar (
    .clk_i(clk), .rst_ni(rst_n), .cfg_sel_i(sel), .cfg_wr_i(wr), .cfg_be_i(be),
    .cfg_wdata_i(wdata), .cfg_rdata_o(rd_m), .mem_en_i(mem_en), .io_en_i(io_en),
    .bus_is_io_i(is_io), .bus_addr_i(addr), .hit_o(hit_m));

  pci_bar #(.BAR_IS_IO(1'b1), .DECODE_LOG2(I_LOG2), .PREFETCH(1'b0)) u_pci_bar_io (
    .clk_i(clk), .rst_ni(rst_n), .cfg_sel_i(sel), .cfg_wr_i(wr), .cfg_be_i(be),
    .cfg_wdata_i(wdata), .cfg_rdata_o(rd_i), .mem_en_i(mem_en), .io_en_i(io_en),
    .bus_is_io_i(is_io), .bus_addr_i(addr), .hit_o(hit_i));

  function automatic logic [31:0] apply_write(logic [31:0] old, logic [31:0] d, logic [3:0] e, int lg);
    logic [31:0] r = old;
    for (int k = 0; k < 32; k++)
      if (k >= lg && e[k/8]) r[k] = d[k];
    return r;
  endfunction

  function automatic logic [31:0] expect_rd(logic [31:0] st, bit io, int lg);
    logic [31:0] m = 32'hFFFF_FFFF << lg;
    return sel ? ((st & m) | (io ? 32'h1 : 32'h8)) : 32'h0;
  endfunction

  function automatic bit expect_hit(logic [31:0] st, bit io, int lg);
    bit en = io ? io_en : mem_en;
    return (is_io == io) && en && ((addr >> lg) == (st >> lg));
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_m <= '0;
      ref_i <= '0;
    end else if (sel && wr) begin
      ref_m <= apply_write(ref_m, wdata, be, M_LOG2);
      ref_i <= apply_write(ref_i, wdata, be, I_LOG2);
    end
  end

  // per-cycle comparison against the reference model
  always @(negedge clk) begin
    cycles++;
    if (rst_n && !done) begin
      check("R1 R2 R3 R5 mem rdata", rd_m, expect_rd(ref_m, 1'b0, M_LOG2));
      check("R1 R2 R3 R5 io rdata", rd_i, expect_rd(ref_i, 1'b1, I_LOG2));
      check("R7 R8 mem hit", {31'b0, hit_m}, {31'b0, expect_hit(ref_m, 1'b0, M_LOG2)});
      check("R7 R8 io hit", {31'b0, hit_i}, {31'b0, expect_hit(ref_i, 1'b1, I_LOG2)});
    end
    if (cycles > 5000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic cfg_write(logic [31:0] d, logic [3:0] e, logic s);
    sel = s; wr = 1'b1; wdata = d; be = e;
    step();
    wr = 1'b0; sel = 1'b1; be = 4'h0;
  endtask

  task automatic at_neg();
    @(negedge clk);
    #1;
  endtask

  initial begin
    step(); step();
    rst_n = 1'b1;
    // R4 reset readback
    sel = 1'b1;
    at_neg();
    check("R4 mem reset", rd_m, 32'h0000_0008);
    check("R4 io reset", rd_i, 32'h0000_0001);
    // R6 unselected reads zero
    sel = 1'b0;
    at_neg();
    check("R6 unselected", rd_m, 32'h0);
    // R3 R9 size probe
    step();
    cfg_write(32'hFFFF_FFFF, 4'hF, 1'b1);
    at_neg();
    check("R3 mem probe", rd_m, 32'hFFFF_F008);
    check("R9 io probe", rd_i, 32'hFFFF_FF01);
    check("R1 io bit0 kept", {31'b0, rd_i[0]}, 32'h1);
    // assign base
    step();
    cfg_write(32'h1234_5FFF, 4'hF, 1'b1);
    at_neg();
    check("R3 mem base", rd_m, 32'h1234_5008);
    check("R2 io base", rd_i, 32'h1234_5F01);
    // R6 write while unselected ignored
    step();
    cfg_write(32'hDEAD_BEEF, 4'hF, 1'b0);
    at_neg();
    check("R6 ignored write", rd_m, 32'h1234_5008);
    // R5 partial lanes 0 and 2
    step();
    cfg_write(32'hAABB_CCDD, 4'b0101, 1'b1);
    at_neg();
    check("R5 mem lanes", rd_m, 32'h12BB_5008);
    check("R5 io lanes", rd_i, 32'h12BB_5F01);
    // R7 hits
    step();
    mem_en = 1'b1; io_en = 1'b1; is_io = 1'b0; addr = 32'h12BB_5ABC;
    at_neg();
    check("R7 mem hit", {31'b0, hit_m}, 32'h1);
    check("R8 io space mismatch", {31'b0, hit_i}, 32'h0);
    is_io = 1'b1; addr = 32'h12BB_5F3C;
    at_neg();
    check("R7 io hit", {31'b0, hit_i}, 32'h1);
    check("R8 mem space mismatch", {31'b0, hit_m}, 32'h0);
    io_en = 1'b0;
    at_neg();
    check("R8 io disabled", {31'b0, hit_i}, 32'h0);
    is_io = 1'b0; mem_en = 1'b0; addr = 32'h12BB_5000;
    at_neg();
    check("R8 mem disabled", {31'b0, hit_m}, 32'h0);
    mem_en = 1'b1; addr = 32'h12BB_6000;
    at_neg();
    check("R7 mem just outside", {31'b0, hit_m}, 32'h0);
    addr = 32'h12BB_5FFF;
    at_neg();
    check("R7 mem top edge", {31'b0, hit_m}, 32'h1);
    // reset again clears writable bits
    step();
    rst_n = 1'b0;
    step();
    rst_n = 1'b1; sel = 1'b1;
    at_neg();
    check("R4 mem re-reset", rd_m, 32'h0000_0008);
    check("R4 io re-reset", rd_i, 32'h0000_0001);
    step(); step();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule